// File: doc/BRIEF.md
# Serial Line Mode Controller

This block sits between the serial side of a UART core and the device pins. Each channel passes its transmit and receive bits either as ordinary serial levels or as infrared signalling levels. In infrared mode a per-channel bit selects how the receive level is interpreted before it goes to the core. The block also inverts the active-low modem-control pins on their way to and from the core. Pulse shaping for infrared links is done by a separate encoder downstream.

Two global strap pins set the starting line mode of every channel. One enables infrared signalling and the other enables automatic RS485 direction control. The straps pass through a synchronizer and are loaded into every channel after an asynchronous reset or a soft reset. The register file can rewrite any mode bit after that, using per-channel write strobes.

When a channel is in RS485 mode, the block drives a driver-enable output. It asserts at the start bit of a character and releases once the last stop bit has been sent. The core supplies one tick per bit period and the frame length in bits.

Top module: `line_mode_ctrl`

## Requirements
- R1: While `rst_ni` is low, all mode bits (`ir_en_o`, `rs485_en_o`, `rx_pol_o`) and `de_o` are 0.
- R2: Both straps pass through a two-flop synchronizer. On the third rising clock edge after `rst_ni` rises, every channel loads `ir_en_o` from `ir_strap_i` and `rs485_en_o` from `rs485_strap_i` (1 = enabled), and `rx_pol_o` is cleared. Before that edge the mode bits stay 0.
- R3: When `soft_rst_i` is high at a rising edge, the same load takes place on the third rising edge after that one. It replaces any mode bits that software wrote earlier. Until then the bits keep their old values.
- R4: When `wr_ir_i[c]`, `wr_rs485_i[c]` or `wr_pol_i[c]` is high at a rising edge, the matching bit of channel c takes the value of `wr_val_i[c]`. Bits of other channels and unstrobed bits do not change. A strap load at the same edge wins over the write.
- R5: With `ir_en_o[c]`=0, `tx_o[c]` equals `core_tx_i[c]`, so the line idles high.
- R6: With `ir_en_o[c]`=1, `tx_o[c]` is the inverse of `core_tx_i[c]`, so the line idles low.
- R7: `core_rx_o[c]` equals `rx_i[c]` when infrared is off. When infrared is on it equals the inverse of `rx_i[c]` if `rx_pol_o[c]`=0, and equals `rx_i[c]` if `rx_pol_o[c]`=1.
- R8: `cts_o`, `dsr_o`, `cd_o` and `ri_o` are the inverses of their `_n_i` pins. `rts_n_o` and `dtr_n_o` are the inverses of `core_rts_i` and `core_dtr_i`.
- R9: With RS485 mode on and no frame in progress, `de_o[c]` goes high in the same cycle that `core_tx_i[c]` goes low. It stays high while the frame is in progress.
- R10: A frame counts `bit_tick_i[c]` pulses at the rising edges after its start. `de_o[c]` falls right after the edge that samples pulse number `frame_bits_i[c]` (which must be at least 1), unless `core_tx_i[c]` is low again at that point.
- R11: With RS485 mode off, `de_o[c]` is 0 and any frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Soft reset request, synchronous |
| ir_strap_i | input | 1 | Infrared start-up strap, active high |
| rs485_strap_i | input | 1 | RS485 start-up strap, high enables |
| wr_ir_i | input | NUM_CH | Write strobe, infrared enable bit |
| wr_rs485_i | input | NUM_CH | Write strobe, RS485 enable bit |
| wr_pol_i | input | NUM_CH | Write strobe, receive polarity bit |
| wr_val_i | input | NUM_CH | Value written by a strobe |
| ir_en_o | output | NUM_CH | Infrared mode bit per channel |
| rs485_en_o | output | NUM_CH | RS485 mode bit per channel |
| rx_pol_o | output | NUM_CH | Infrared receive polarity bit |
| core_tx_i | input | NUM_CH | Serial data from the core |
| tx_o | output | NUM_CH | Transmit pin |
| rx_i | input | NUM_CH | Receive pin |
| core_rx_o | output | NUM_CH | Receive data to the core |
| bit_tick_i | input | NUM_CH | One pulse per transmitted bit period |
| frame_bits_i | input | NUM_CH*FRAME_W | Bits per character, start through stop |
| de_o | output | NUM_CH | RS485 driver enable |
| core_rts_i | input | NUM_CH | Request-to-send from the core |
| core_dtr_i | input | NUM_CH | Terminal-ready from the core |
| rts_n_o | output | NUM_CH | Request-to-send pin, active low |
| dtr_n_o | output | NUM_CH | Terminal-ready pin, active low |
| cts_n_i | input | NUM_CH | Clear-to-send pin, active low |
| dsr_n_i | input | NUM_CH | Data-set-ready pin, active low |
| cd_n_i | input | NUM_CH | Carrier-detect pin, active low |
| ri_n_i | input | NUM_CH | Ring pin, active low |
| cts_o | output | NUM_CH | Clear-to-send to the core |
| dsr_o | output | NUM_CH | Data-set-ready to the core |
| cd_o | output | NUM_CH | Carrier-detect to the core |
| ri_o | output | NUM_CH | Ring to the core |

## Verification
The assertions assume that `frame_bits_i` is at least 1 and stays constant while a frame is in progress. They also assume that `bit_tick_i` and `core_tx_i` change only between clock edges, as a core driven from the same clock would do. The stimulus keeps to this. Each frame length is chosen in 1..12 and held for the whole frame. All inputs change on the falling clock edge. Write strobes are never issued during a strap load window, so the load-over-write priority is checked only by the assertions.

// File: rtl/lm_pkg.sv
`timescale 1ns/1ps
package lm_pkg;
  typedef enum logic {DE_IDLE = 1'b0, DE_BUSY = 1'b1} de_state_e;

  typedef struct packed {
    logic ir;
    logic rs485;
    logic pol;
  } mode_t;
endpackage

// File: rtl/lm_strap_capture.sv
`timescale 1ns/1ps
module lm_strap_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic ir_strap_i,
  input  logic rs485_strap_i,
  output logic ir_sync_o,
  output logic rs485_sync_o,
  output logic load_o
);
  localparam int WAIT_INIT = SYNC_STAGES + 1;
  localparam int WAIT_W    = $clog2(WAIT_INIT + 1);

  logic [SYNC_STAGES-1:0] ir_ff_q, rs_ff_q;
  logic [WAIT_W-1:0]      wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_ff_q <= '0;
      rs_ff_q <= '0;
    end else begin
      ir_ff_q <= {ir_ff_q[SYNC_STAGES-2:0], ir_strap_i};
      rs_ff_q <= {rs_ff_q[SYNC_STAGES-2:0], rs485_strap_i};
    end
  end

  // counts down through synchronizer latency; load fires on the last step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wait_q <= WAIT_W'(WAIT_INIT);
    else if (soft_rst_i)        wait_q <= WAIT_W'(WAIT_INIT);
    else if (wait_q != '0)      wait_q <= wait_q - 1'b1;
  end

  assign ir_sync_o    = ir_ff_q[SYNC_STAGES-1];
  assign rs485_sync_o = rs_ff_q[SYNC_STAGES-1];
  assign load_o       = (wait_q == WAIT_W'(1));
endmodule

// File: rtl/lm_mode_reg.sv
`timescale 1ns/1ps
module lm_mode_reg
  import lm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  ir_strap_i,
  input  logic  rs485_strap_i,
  input  logic  wr_ir_i,
  input  logic  wr_rs485_i,
  input  logic  wr_pol_i,
  input  logic  wr_val_i,
  output mode_t mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (load_i) begin
      mode_q.ir    <= ir_strap_i;
      mode_q.rs485 <= rs485_strap_i;
      mode_q.pol   <= 1'b0;
    end else begin
      if (wr_ir_i)    mode_q.ir    <= wr_val_i;
      if (wr_rs485_i) mode_q.rs485 <= wr_val_i;
      if (wr_pol_i)   mode_q.pol   <= wr_val_i;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lm_line_path.sv
`timescale 1ns/1ps
module lm_line_path (
  input  logic ir_en_i,
  input  logic rx_pol_i,
  input  logic core_tx_i,
  output logic tx_o,
  input  logic rx_i,
  output logic core_rx_o,
  input  logic core_rts_i,
  input  logic core_dtr_i,
  output logic rts_n_o,
  output logic dtr_n_o,
  input  logic cts_n_i,
  input  logic dsr_n_i,
  input  logic cd_n_i,
  input  logic ri_n_i,
  output logic cts_o,
  output logic dsr_o,
  output logic cd_o,
  output logic ri_o
);
  always_comb begin
    tx_o      = ir_en_i ? ~core_tx_i : core_tx_i;
    // infrared line idles low; pol=0 treats a low pin as mark
    core_rx_o = (ir_en_i && !rx_pol_i) ? ~rx_i : rx_i;
  end

  assign rts_n_o = ~core_rts_i;
  assign dtr_n_o = ~core_dtr_i;
  assign cts_o   = ~cts_n_i;
  assign dsr_o   = ~dsr_n_i;
  assign cd_o    = ~cd_n_i;
  assign ri_o    = ~ri_n_i;
endmodule

// File: rtl/lm_de_ctrl.sv
`timescale 1ns/1ps
module lm_de_ctrl
  import lm_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               core_tx_i,
  input  logic               bit_tick_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  output logic               de_o
);
  de_state_e          state_q;
  logic [FRAME_W-1:0] cnt_q;
  logic               start;
  logic               last_bit;

  assign start    = en_i && (state_q == DE_IDLE) && !core_tx_i;
  assign last_bit = (cnt_q == frame_bits_i - FRAME_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DE_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= DE_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= DE_BUSY;
      cnt_q   <= '0;
    end else if (state_q == DE_BUSY && bit_tick_i) begin
      if (last_bit) begin
        state_q <= DE_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // combinational start term keeps the driver on for the first start-bit cycle
  assign de_o = en_i && ((state_q == DE_BUSY) || !core_tx_i);
endmodule

// File: rtl/line_mode_ctrl.sv
`timescale 1ns/1ps
module line_mode_ctrl
  import lm_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int FRAME_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       soft_rst_i,
  input  logic                       ir_strap_i,
  input  logic                       rs485_strap_i,
  input  logic [NUM_CH-1:0]          wr_ir_i,
  input  logic [NUM_CH-1:0]          wr_rs485_i,
  input  logic [NUM_CH-1:0]          wr_pol_i,
  input  logic [NUM_CH-1:0]          wr_val_i,
  output logic [NUM_CH-1:0]          ir_en_o,
  output logic [NUM_CH-1:0]          rs485_en_o,
  output logic [NUM_CH-1:0]          rx_pol_o,
  input  logic [NUM_CH-1:0]          core_tx_i,
  output logic [NUM_CH-1:0]          tx_o,
  input  logic [NUM_CH-1:0]          rx_i,
  output logic [NUM_CH-1:0]          core_rx_o,
  input  logic [NUM_CH-1:0]          bit_tick_i,
  input  logic [NUM_CH*FRAME_W-1:0]  frame_bits_i,
  output logic [NUM_CH-1:0]          de_o,
  input  logic [NUM_CH-1:0]          core_rts_i,
  input  logic [NUM_CH-1:0]          core_dtr_i,
  output logic [NUM_CH-1:0]          rts_n_o,
  output logic [NUM_CH-1:0]          dtr_n_o,
  input  logic [NUM_CH-1:0]          cts_n_i,
  input  logic [NUM_CH-1:0]          dsr_n_i,
  input  logic [NUM_CH-1:0]          cd_n_i,
  input  logic [NUM_CH-1:0]          ri_n_i,
  output logic [NUM_CH-1:0]          cts_o,
  output logic [NUM_CH-1:0]          dsr_o,
  output logic [NUM_CH-1:0]          cd_o,
  output logic [NUM_CH-1:0]          ri_o
);
  logic ir_sync, rs485_sync, strap_load;

  lm_strap_capture #(.SYNC_STAGES(SYNC_STAGES)) u_strap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .ir_strap_i    (ir_strap_i),
    .rs485_strap_i (rs485_strap_i),
    .ir_sync_o     (ir_sync),
    .rs485_sync_o  (rs485_sync),
    .load_o        (strap_load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mode_t mode;

    lm_mode_reg u_mode (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .load_i        (strap_load),
      .ir_strap_i    (ir_sync),
      .rs485_strap_i (rs485_sync),
      .wr_ir_i       (wr_ir_i[c]),
      .wr_rs485_i    (wr_rs485_i[c]),
      .wr_pol_i      (wr_pol_i[c]),
      .wr_val_i      (wr_val_i[c]),
      .mode_o        (mode)
    );

    assign ir_en_o[c]    = mode.ir;
    assign rs485_en_o[c] = mode.rs485;
    assign rx_pol_o[c]   = mode.pol;

    lm_line_path u_path (
      .ir_en_i    (mode.ir),
      .rx_pol_i   (mode.pol),
      .core_tx_i  (core_tx_i[c]),
      .tx_o       (tx_o[c]),
      .rx_i       (rx_i[c]),
      .core_rx_o  (core_rx_o[c]),
      .core_rts_i (core_rts_i[c]),
      .core_dtr_i (core_dtr_i[c]),
      .rts_n_o    (rts_n_o[c]),
      .dtr_n_o    (dtr_n_o[c]),
      .cts_n_i    (cts_n_i[c]),
      .dsr_n_i    (dsr_n_i[c]),
      .cd_n_i     (cd_n_i[c]),
      .ri_n_i     (ri_n_i[c]),
      .cts_o      (cts_o[c]),
      .dsr_o      (dsr_o[c]),
      .cd_o       (cd_o[c]),
      .ri_o       (ri_o[c])
    );

    lm_de_ctrl #(.FRAME_W(FRAME_W)) u_de (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (mode.rs485),
      .core_tx_i    (core_tx_i[c]),
      .bit_tick_i   (bit_tick_i[c]),
      .frame_bits_i (frame_bits_i[c*FRAME_W +: FRAME_W]),
      .de_o         (de_o[c])
    );
  end
endmodule

// File: rtl/line_mode_ctrl_chk.sv
`timescale 1ns/1ps
module line_mode_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              ir_sync_i,
  input logic              rs485_sync_i,
  input logic [NUM_CH-1:0] wr_ir_i,
  input logic [NUM_CH-1:0] wr_rs485_i,
  input logic [NUM_CH-1:0] wr_val_i,
  input logic [NUM_CH-1:0] ir_en_i,
  input logic [NUM_CH-1:0] rs485_en_i,
  input logic [NUM_CH-1:0] rx_pol_i,
  input logic [NUM_CH-1:0] core_tx_i,
  input logic [NUM_CH-1:0] bit_tick_i,
  input logic [NUM_CH-1:0] de_i
);
  assert_strap_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ir_en_i == {NUM_CH{$past(ir_sync_i)}}) &&
               (rs485_en_i == {NUM_CH{$past(rs485_sync_i)}}) && (rx_pol_i == '0));

  assert_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (((ir_en_i ^ $past(wr_val_i)) & $past(wr_ir_i)) == '0) &&
                (((rs485_en_i ^ $past(wr_val_i)) & $past(wr_rs485_i)) == '0));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (((ir_en_i ^ $past(ir_en_i)) & ~$past(wr_ir_i)) == '0) &&
                (((rs485_en_i ^ $past(rs485_en_i)) & ~$past(wr_rs485_i)) == '0));

  assert_de_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((de_i & ~$past(de_i)) & core_tx_i) == '0);

  assert_de_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~de_i & $past(de_i)) & rs485_en_i & ~$past(bit_tick_i)) == '0);
endmodule

bind line_mode_ctrl line_mode_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (strap_load),
  .ir_sync_i    (ir_sync),
  .rs485_sync_i (rs485_sync),
  .wr_ir_i      (wr_ir_i),
  .wr_rs485_i   (wr_rs485_i),
  .wr_val_i     (wr_val_i),
  .ir_en_i      (ir_en_o),
  .rs485_en_i   (rs485_en_o),
  .rx_pol_i     (rx_pol_o),
  .core_tx_i    (core_tx_i),
  .bit_tick_i   (bit_tick_i),
  .de_i         (de_o)
);

// File: tb/line_mode_ctrl_bench.sv
`timescale 1ns/1ps
module line_mode_ctrl_bench;
  localparam int N  = 2;
  localparam int FW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0, soft_rst = 1'b0, ir_strap = 1'b0, rs_strap = 1'b0;
  logic [N-1:0] wr_ir = '0, wr_rs = '0, wr_pol = '0, wr_val = '0;
  logic [N-1:0] ir_en, rs_en, rx_pol;
  logic [N-1:0] core_tx = '1, tx, rx = '1, core_rx, tick = '0, de;
  logic [N*FW-1:0] frame = '0;
  logic [N-1:0] rts = '0, dtr = '0, rts_n, dtr_n;
  logic [N-1:0] cts_n = '1, dsr_n = '1, cd_n = '1, ri_n = '1, cts, dsr, cd, ri;

  line_mode_ctrl #(.NUM_CH(N), .FRAME_W(FW)) u_line_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .ir_strap_i(ir_strap), .rs485_strap_i(rs_strap),
    .wr_ir_i(wr_ir), .wr_rs485_i(wr_rs), .wr_pol_i(wr_pol), .wr_val_i(wr_val),
    .ir_en_o(ir_en), .rs485_en_o(rs_en), .rx_pol_o(rx_pol),
    .core_tx_i(core_tx), .tx_o(tx), .rx_i(rx), .core_rx_o(core_rx),
    .bit_tick_i(tick), .frame_bits_i(frame), .de_o(de),
    .core_rts_i(rts), .core_dtr_i(dtr), .rts_n_o(rts_n), .dtr_n_o(dtr_n),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .cd_n_i(cd_n), .ri_n_i(ri_n),
    .cts_o(cts), .dsr_o(dsr), .cd_o(cd), .ri_o(ri)
  );

  int checks = 0, errors = 0;
  logic [N-1:0] m_ir = '0, m_rs = '0, m_pol = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tx(logic ir_b, logic d);
    return ir_b ? ~d : d;
  endfunction

  function automatic logic exp_rx(logic ir_b, logic pol_b, logic pin);
    if (!ir_b) return pin;
    return pol_b ? pin : ~pin;
  endfunction

  task automatic check_modes(string req);
    chk({req, " ir_en"}, 32'(ir_en), 32'(m_ir));
    chk({req, " rs485_en"}, 32'(rs_en), 32'(m_rs));
    chk({req, " rx_pol"}, 32'(rx_pol), 32'(m_pol));
  endtask

  // kind: 0 infrared, 1 rs485, 2 polarity
  task automatic wr_mode(int ch, int kind, logic v);
    @(negedge clk);
    wr_val[ch] = v;
    case (kind)
      0: wr_ir[ch]  = 1'b1;
      1: wr_rs[ch]  = 1'b1;
      default: wr_pol[ch] = 1'b1;
    endcase
    @(negedge clk);
    wr_ir = '0; wr_rs = '0; wr_pol = '0;
    case (kind)
      0: m_ir[ch]  = v;
      1: m_rs[ch]  = v;
      default: m_pol[ch] = v;
    endcase
    check_modes("R4");
  endtask

  task automatic do_reset(logic irs, logic rss);
    @(negedge clk);
    ir_strap = irs; rs_strap = rss; rst_ni = 1'b0;
    #1;
    chk("R1 ir_en", 32'(ir_en), 0);
    chk("R1 rs485_en", 32'(rs_en), 0);
    chk("R1 de", 32'(de), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 before load", 32'({ir_en, rs_en}), 0);
    @(negedge clk);
    m_ir = {N{irs}}; m_rs = {N{rss}}; m_pol = '0;
    check_modes("R2");
  endtask

  task automatic de_frame(int ch, int f);
    frame[ch*FW +: FW] = FW'(f);
    @(negedge clk);
    core_tx[ch] = 1'b0;
    #1 chk("R9 de at start bit", 32'(de[ch]), 1);
    for (int k = 1; k <= f; k++) begin
      int gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        core_tx[ch] = 1'($urandom);
        chk("R9 de held", 32'(de[ch]), 1);
      end
      @(negedge clk);
      tick[ch] = 1'b1;
      core_tx[ch] = (k == f) ? 1'b1 : 1'($urandom);
      @(negedge clk);
      tick[ch] = 1'b0;
      chk(k < f ? "R10 de mid frame" : "R10 de release", 32'(de[ch]), (k < f) ? 1 : 0);
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1a2b3c));
    do_reset(1'b1, 1'b0);
    do_reset(1'b0, 1'b1);

    // R3: software-written bits replaced by a soft reset load
    wr_mode(0, 0, 1'b1);
    wr_mode(1, 2, 1'b1);
    @(negedge clk);
    ir_strap = 1'b0; rs_strap = 1'b0; soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_modes("R3 before load");
    @(negedge clk);
    m_ir = '0; m_rs = '0; m_pol = '0;
    check_modes("R3");

    // R5..R8 random line-path patterns
    for (int i = 0; i < 300; i++) begin
      wr_mode($urandom_range(0, N - 1), $urandom_range(0, 2), 1'($urandom));
      @(negedge clk);
      core_tx = N'($urandom); rx = N'($urandom);
      rts = N'($urandom); dtr = N'($urandom);
      cts_n = N'($urandom); dsr_n = N'($urandom); cd_n = N'($urandom); ri_n = N'($urandom);
      #1;
      for (int c = 0; c < N; c++) begin
        chk(m_ir[c] ? "R6 tx" : "R5 tx", 32'(tx[c]), 32'(exp_tx(m_ir[c], core_tx[c])));
        chk("R7 rx", 32'(core_rx[c]), 32'(exp_rx(m_ir[c], m_pol[c], rx[c])));
      end
      chk("R8 modem out", 32'({rts_n, dtr_n}), 32'({~rts, ~dtr}));
      chk("R8 modem in", 32'({cts, dsr, cd, ri}), 32'({~cts_n, ~dsr_n, ~cd_n, ~ri_n}));
    end

    // idle lines, RS485 off everywhere to clear any frame state
    @(negedge clk); core_tx = '1;
    for (int c = 0; c < N; c++) wr_mode(c, 1, 1'b0);

    // R11: RS485 off keeps de low
    @(negedge clk); core_tx[0] = 1'b0; tick[0] = 1'b1;
    @(negedge clk); tick[0] = 1'b0;
    chk("R11 de off", 32'(de), 0);
    @(negedge clk); core_tx[0] = 1'b1;

    // R9/R10 directed and random frames
    for (int c = 0; c < N; c++) wr_mode(c, 1, 1'b1);
    de_frame(0, 1);
    de_frame(1, 12);
    for (int i = 0; i < 40; i++) de_frame($urandom_range(0, N - 1), $urandom_range(1, 12));

    // R11: disable in mid-frame drops de
    frame[0 +: FW] = FW'(8);
    @(negedge clk); core_tx[0] = 1'b0;
    @(negedge clk);
    chk("R9 frame started", 32'(de[0]), 1);
    wr_mode(0, 1, 1'b0);
    chk("R11 de dropped", 32'(de[0]), 0);
    @(negedge clk); core_tx[0] = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule